// File: doc/BRIEF.md
# Hex Display and Switch Input Port Unit

This unit answers the port read and write strobes issued by a small processor core. It decodes an 8-bit port code and owns two ports: a display port and a switch port. The display port is an 8-bit latch. Software writes a byte into it, and a read returns the last byte written. The latch also drives two 7-segment digits that show its value as two hexadecimal characters. The switch port is read-only. It reports eight on/off switches after they pass through a two-flop synchronizer. A write to the switch port changes nothing.

All outputs are registered. A read strobe sampled at one clock edge presents its data on `rd_data` right after that edge. A write to the display port updates the latch at the edge that samples the strobe. The segment drives follow one edge later. Any port code other than the two owned ones reads as zero and ignores writes. Reset is synchronous and active-high.

Top module: `ioport_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the display latch is cleared to 0x00, `rd_data` becomes 0x00 and both digits show the glyph for 0 (`seg_out` = 14'h1FBF).
- R2: A write to port code 0x00 stores `wr_data`. A later read of port code 0x00 returns the stored byte on `rd_data` just after the edge that samples the read strobe.
- R3: After an edge where `rd_en` is low, `rd_data` is 0x00.
- R4: A read of port code 0x01 returns the synchronized switches, with switch n on bit n and 1 meaning on. Take the edge that first samples a new switch value. A read sampled at the next edge still returns the older value. A read sampled two or more edges later returns the new one.
- R5: A write to port code 0x01 leaves the display latch and the segment outputs unchanged.
- R6: A read of any port code other than 0x00 and 0x01 returns 0x00, and a write to such a code leaves the display latch unchanged.
- R7: The segments are active-high, with bit 6 = g down to bit 0 = a within each 7-bit digit. `seg_out[13:7]` shows the high nibble and `seg_out[6:0]` shows the low nibble. The codes for 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71 (hex), giving glyphs A, b, C, d, E, F for the letters.
- R8: Suppose a display write is sampled at edge k. Then `seg_out` still shows the old value after edge k and shows the new value after edge k+1.
- R9: A read and a write of port code 0x00 sampled at the same edge return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 8 | Port code for the current access |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sw_in | input | 8 | Asynchronous switch levels, 1 = on |
| rd_data | output | 8 | Registered read data |
| seg_out | output | 14 | Two digit drives, high digit in bits 13:7 |

## Verification
Only two kinds of state can go wrong here: the display latch and the synchronizer chain. A corrupted latch shows up at the ports one edge later on a port-0 read, and one further edge later on `seg_out`. The bench therefore checks the read data and the digit glyphs together after every vector. A synchronizer with the wrong depth shows up as a switch change that reaches `rd_data` one edge early or late. The bench pins this down with reads placed on consecutive edges around a change.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  typedef enum logic [1:0] {
    SEL_DISP = 2'd0,
    SEL_SW   = 2'd1,
    SEL_NONE = 2'd2
  } port_sel_e;

  // active-high segment pattern, bit 6 = g ... bit 0 = a
  function automatic logic [6:0] seg_of_nibble(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ioport_sync.sv
module ioport_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  // cycles since reset, saturating; used only to qualify the latency check
  logic [1:0] since_rst_q;
  always_ff @(posedge clk) begin
    if (rst)                     since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == 2'd3) |-> (sync_o == $past(async_i, 2))); // R4
    end
  endgenerate

endmodule

// File: rtl/ioport_disp_latch.sv
module ioport_disp_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] value_o
);

  always_ff @(posedge clk) begin
    if (rst)         value_o <= '0;
    else if (wr_hit) value_o <= wr_data;
  end

  AST_WR_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (value_o == $past(wr_data))); // R2

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(value_o)); // R5 R6

endmodule

// File: rtl/ioport_hex_seg.sv
module ioport_hex_seg #(
  parameter int DATA_W = 8,
  localparam int DIGITS = DATA_W / 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   value_i,
  output logic [DIGITS*7-1:0] seg_o
);
  import ioport_pkg::*;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      always_ff @(posedge clk) begin
        if (rst) seg_o[d*7 +: 7] <= seg_of_nibble(4'h0);
        else     seg_o[d*7 +: 7] <= seg_of_nibble(value_i[d*4 +: 4]);
      end

      AST_SEG_LIT: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_o[d*7 +: 7]) >= 2); // R7
    end
  endgenerate

endmodule

// File: rtl/ioport_rd_mux.sv
module ioport_rd_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DISP_CODE = '0,
  parameter logic [ADDR_W-1:0] SW_CODE   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] disp_val,
  input  logic [DATA_W-1:0] sw_val,
  output logic [DATA_W-1:0] rd_data
);
  import ioport_pkg::*;

  port_sel_e sel;

  always_comb begin
    if (addr == DISP_CODE)    sel = SEL_DISP;
    else if (addr == SW_CODE) sel = SEL_SW;
    else                      sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rd_data <= '0;
    else begin
      case (sel)
        SEL_DISP: rd_data <= disp_val;
        SEL_SW:   rd_data <= sw_val;
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != DISP_CODE && addr != SW_CODE) |=> (rd_data == '0)); // R6

endmodule

// File: rtl/ioport_unit.sv
module ioport_unit #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DIGITS     = DATA_W / 4,
  localparam int SEG_W      = DIGITS * 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEG_W-1:0]  seg_out
);

  localparam logic [ADDR_W-1:0] DISP_CODE = '0;
  localparam logic [ADDR_W-1:0] SW_CODE   = 1;

  logic [DATA_W-1:0] sw_sync;
  logic [DATA_W-1:0] disp_val;
  logic              disp_wr;

  assign disp_wr = wr_en && (port_addr == DISP_CODE);

  ioport_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(sw_in), .sync_o(sw_sync)
  );

  ioport_disp_latch #(.DATA_W(DATA_W)) latch_i (
    .clk(clk), .rst(rst), .wr_hit(disp_wr), .wr_data(wr_data), .value_o(disp_val)
  );

  ioport_hex_seg #(.DATA_W(DATA_W)) seg_i (
    .clk(clk), .rst(rst), .value_i(disp_val), .seg_o(seg_out)
  );

  ioport_rd_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_CODE(DISP_CODE), .SW_CODE(SW_CODE)
  ) mux_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(port_addr),
    .disp_val(disp_val), .sw_val(sw_sync), .rd_data(rd_data)
  );

  AST_SW_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == SW_CODE) |=> $stable(disp_val)); // R5

endmodule

// File: tb/ioport_unit_tb.sv
module ioport_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] port_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic       wr_en;
  logic [7:0] sw_in;
  logic [7:0] rd_data;
  logic [13:0] seg_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ioport_unit dut_i (
    .clk(clk), .rst(rst), .port_addr(port_addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .sw_in(sw_in), .rd_data(rd_data), .seg_out(seg_out)
  );

  // glyph codes as listed in R7
  function automatic logic [6:0] glyph(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic logic [13:0] disp_segs(input logic [7:0] v);
    return {glyph(v[7:4]), glyph(v[3:0])};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // {do_wr, wr_addr, wr_data, rd_addr, sw, exp_rd, exp_disp}
  localparam int NV = 15;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h5A},
    {1'b1, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h5A, 8'h5A},
    {1'b0, 8'h00, 8'h00, 8'h01, 8'hA5, 8'hA5, 8'h5A},
    {1'b1, 8'h07, 8'h33, 8'h00, 8'hA5, 8'h5A, 8'h5A},
    {1'b0, 8'h00, 8'h00, 8'h02, 8'hFF, 8'h00, 8'h5A},
    {1'b1, 8'h00, 8'h01, 8'h01, 8'h3C, 8'h3C, 8'h01},
    {1'b1, 8'h00, 8'h23, 8'h00, 8'h3C, 8'h23, 8'h23},
    {1'b1, 8'h00, 8'h45, 8'h00, 8'h00, 8'h45, 8'h45},
    {1'b1, 8'h00, 8'h67, 8'h00, 8'h00, 8'h67, 8'h67},
    {1'b1, 8'h00, 8'h89, 8'h00, 8'h00, 8'h89, 8'h89},
    {1'b1, 8'h00, 8'hAB, 8'h00, 8'h00, 8'hAB, 8'hAB},
    {1'b1, 8'h00, 8'hCD, 8'hFF, 8'h81, 8'h00, 8'hCD},
    {1'b1, 8'h00, 8'hEF, 8'h01, 8'h81, 8'h81, 8'hEF},
    {1'b1, 8'h80, 8'h11, 8'h00, 8'h81, 8'hEF, 8'hEF},
    {1'b1, 8'h00, 8'hF0, 8'h00, 8'h00, 8'hF0, 8'hF0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; port_addr = '0; wr_data = '0; rd_en = 1'b0; wr_en = 1'b0; sw_in = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", 32'(rd_data), 32'h00);
    check("R1 seg_out in reset", 32'(seg_out), 32'h1FBF);
    rst = 1'b0;
    @(negedge clk);
    rd_en = 1'b1; port_addr = 8'h00;
    @(negedge clk);
    rd_en = 1'b0;
    check("R1 latch after reset", 32'(rd_data), 32'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      sw_in = v[23:16];
      repeat (3) @(negedge clk);
      if (v[48]) begin
        wr_en = 1'b1; port_addr = v[47:40]; wr_data = v[39:32];
        @(negedge clk);
        wr_en = 1'b0;
      end
      rd_en = 1'b1; port_addr = v[31:24];
      @(negedge clk);
      rd_en = 1'b0;
      check($sformatf("R2/R4/R5/R6 vector %0d rd_data", i), 32'(rd_data), 32'(v[15:8]));
      check($sformatf("R7 vector %0d seg_out", i), 32'(seg_out), 32'(disp_segs(v[7:0])));
      @(negedge clk);
      check($sformatf("R3 vector %0d idle rd_data", i), 32'(rd_data), 32'h00);
    end

    // R8: segment timing around a display write (latch holds F0)
    wr_en = 1'b1; port_addr = 8'h00; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 seg old after write edge", 32'(seg_out), 32'(disp_segs(8'hF0)));
    @(negedge clk);
    check("R8 seg new one edge later", 32'(seg_out), 32'(disp_segs(8'h3C)));

    // R9: read and write of port 0 at the same edge
    wr_en = 1'b1; rd_en = 1'b1; port_addr = 8'h00; wr_data = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 same-edge read returns old", 32'(rd_data), 32'h3C);
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 next read returns new", 32'(rd_data), 32'h77);

    // R4: synchronizer latency
    sw_in = 8'h00;
    repeat (4) @(negedge clk);
    sw_in = 8'h96;
    @(negedge clk);
    rd_en = 1'b1; port_addr = 8'h01;
    @(negedge clk);
    check("R4 read at next edge is old", 32'(rd_data), 32'h00);
    @(negedge clk);
    rd_en = 1'b0;
    check("R4 read two edges later is new", 32'(rd_data), 32'h96);

    // R5: port 1 write leaves display alone (latch holds 77)
    wr_en = 1'b1; port_addr = 8'h01; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R5 seg after port 1 write", 32'(seg_out), 32'(disp_segs(8'h77)));

    // R1: mid-run reset clears the latch
    rst = 1'b1;
    @(negedge clk);
    check("R1 seg after mid-run reset", 32'(seg_out), 32'h1FBF);
    rst = 1'b0;
    rd_en = 1'b1; port_addr = 8'h00;
    @(negedge clk);
    rd_en = 1'b0;
    check("R1 latch after mid-run reset", 32'(rd_data), 32'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule